// File: doc/BRIEF.md
# DS2 AIS Window Detector

This block watches seven DS2 serial data streams for an alarm indication signal: a stream held at all ones. Every channel has its own bit strobe that marks the clock cycles carrying a valid data bit. Every channel also runs its own free-running window of 840 strobed bits, with no tie to any frame. Each window is graded by the number of zero bits it contains. The grade feeds a two-window hysteresis that raises or drops the channel's AIS flag.

The seven flags are packed into one status word for a register read. Channel 0 sits in the least significant bit and the unused upper bits read as zero. Clock recovery, loss-of-clock detection and frame alignment are handled elsewhere; this block only consumes strobed bits.

Top module: `ds2_ais_monitor`

## Requirements
- R1: A channel's window spans exactly 840 bits taken on cycles where that channel's strobe is high. Data on cycles with the strobe low is ignored and does not advance the window.
- R2: A window is graded AIS-like when fewer than 5 of its 840 bits are 0. The final bit of the window counts toward its own grade.
- R3: A channel's flag becomes 1 when two windows in a row are graded AIS-like.
- R4: A channel's flag becomes 0 when two windows in a row each contain 5 or more zeros.
- R5: The flag changes only at a window boundary. It is updated in the clock cycle after the strobe of the window's last bit. A window whose grade differs from the grade of the window before it leaves the flag unchanged.
- R6: Channels run independently. Strobes, data and window phases of one channel have no effect on any other channel's flag.
- R7: Bit i of `status_word` (i from 0 to 6) carries channel i's flag. Bits 15 down to 7 always read 0.
- R8: While `rst_n` is low at a rising clock edge, all window positions, zero counts, previous-window grades and flags clear to 0. After reset the previous grade counts as not AIS-like, so the first AIS-like window alone does not raise a flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all channels |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 7 | Per-channel strobe marking a valid data bit |
| bit_in | input | 7 | Per-channel serial data bit |
| status_word | output | 16 | AIS flags in bits 6:0, zeros above |

## Verification
Two things can happen in the same cycle: closing a window and counting that window's last bit. When the final strobed bit is a zero, it must count toward the closing window's grade, and the zero counter must restart for the next window in that same edge. The bench provokes this by placing the zeros of every odd-numbered window at its tail, and by sweeping zero counts from 0 to 7 across the AIS threshold. Channels 0, 3 and 6 run at the full strobe rate, so their window boundaries fall in the same cycle. The bench's per-channel model predicts every flag independently, and the full status word is compared against that prediction on every cycle.

// File: rtl/ds2_ais_pkg.sv
// Package: shared defaults and the per-window result record.
// Assumes: used by every module of the DS2 AIS detector.
package ds2_ais_pkg;

    localparam int unsigned DEF_CHANNELS   = 7;
    localparam int unsigned DEF_WIN_BITS   = 840;
    localparam int unsigned DEF_ZERO_LIMIT = 5;
    localparam int unsigned DEF_WORD_W     = 16;

    // Grade of one closing window, valid for the single cycle in which it closes.
    typedef struct packed {
        logic done;      // last strobed bit of the window is being taken
        logic ais_like;  // fewer than ZERO_LIMIT zeros, last bit included
    } win_grade_t;

endpackage

// File: rtl/ds2_ais_window.sv
// Module: ds2_ais_window
// Counts strobed bits into free-running windows of WIN_BITS. It also counts the
// zeros in each window, saturating at ZERO_LIMIT. When the last bit of a window
// is strobed in, it presents the window's grade combinationally.
// Assumes: bit_in is meaningful only when bit_en is high; reset is synchronous.
module ds2_ais_window
    import ds2_ais_pkg::*;
#(
    parameter int unsigned WIN_BITS   = DEF_WIN_BITS,
    parameter int unsigned ZERO_LIMIT = DEF_ZERO_LIMIT
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       bit_in,
    output win_grade_t grade
);

    localparam int unsigned POS_W  = $clog2(WIN_BITS);
    localparam int unsigned ZC_W   = $clog2(ZERO_LIMIT + 1);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WIN_BITS - 1);
    localparam logic [ZC_W-1:0]  ZC_MAX   = ZC_W'(ZERO_LIMIT);

    logic [POS_W-1:0] pos_q;
    logic [ZC_W-1:0]  zeros_q;
    logic [ZC_W-1:0]  zeros_with_bit;
    logic             at_last;

    // Zero count including the bit offered this cycle, held at the limit.
    always_comb begin
        zeros_with_bit = zeros_q;
        if (!bit_in && (zeros_q != ZC_MAX)) begin
            zeros_with_bit = zeros_q + 1'b1;
        end
    end

    assign at_last        = bit_en && (pos_q == LAST_POS);
    assign grade.done     = at_last;
    assign grade.ais_like = (zeros_with_bit < ZC_MAX);

    // Advance the window position and the zero count on each strobed bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= '0;
            zeros_q <= '0;
        end else if (bit_en) begin
            if (at_last) begin
                pos_q   <= '0;
                zeros_q <= '0;
            end else begin
                pos_q   <= pos_q + 1'b1;
                zeros_q <= zeros_with_bit;
            end
        end
    end

    // R1: the window position never leaves its range.
    a_r1_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= LAST_POS)
        else $error("window position beyond last bit");

    // R1: without a strobe the window does not move.
    a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(pos_q) && $stable(zeros_q))
        else $error("window state moved without strobe");

    // R2: the zero counter saturates at the limit.
    a_r2_zero_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        zeros_q <= ZC_MAX)
        else $error("zero counter beyond limit");

    // R1: a closing window restarts at position zero.
    a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        at_last |=> (pos_q == '0) && (zeros_q == '0))
        else $error("window did not restart");

endmodule

// File: rtl/ds2_ais_hyst.sv
// Module: ds2_ais_hyst
// Keeps the grade of the previous window and applies the two-window rule.
// The flag takes the current grade only when it matches the previous one.
// Assumes: grade.done pulses for one cycle per window; reset is synchronous.
module ds2_ais_hyst
    import ds2_ais_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  win_grade_t grade,
    output logic       ais_flag
);

    logic prev_like_q;

    // Record each window's grade and confirm the flag on two matching grades.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_like_q <= 1'b0;
            ais_flag    <= 1'b0;
        end else if (grade.done) begin
            prev_like_q <= grade.ais_like;
            if (grade.ais_like == prev_like_q) begin
                ais_flag <= grade.ais_like;
            end
        end
    end

    // R3: two AIS-like windows in a row raise the flag.
    a_r3_set_on_pair: assert property (@(posedge clk) disable iff (!rst_n)
        grade.done && grade.ais_like && prev_like_q |=> ais_flag)
        else $error("flag not raised after two AIS-like windows");

    // R4: two windows with many zeros in a row drop the flag.
    a_r4_clear_on_pair: assert property (@(posedge clk) disable iff (!rst_n)
        grade.done && !grade.ais_like && !prev_like_q |=> !ais_flag)
        else $error("flag not dropped after two errored windows");

    // R5: between window boundaries the flag is frozen.
    a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !grade.done |=> $stable(ais_flag))
        else $error("flag moved outside a window boundary");

    // R5: a grade that differs from the previous one leaves the flag alone.
    a_r5_hold_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        grade.done && (grade.ais_like != prev_like_q) |=> $stable(ais_flag))
        else $error("flag moved on a single window");

endmodule

// File: rtl/ds2_ais_monitor.sv
// Module: ds2_ais_monitor
// Top of the DS2 AIS detector. It builds one window counter and one
// hysteresis stage per channel and packs the flags into a register word.
// Assumes: each strobe is already in the clk domain; WORD_W >= CHANNELS.
module ds2_ais_monitor
    import ds2_ais_pkg::*;
#(
    parameter int unsigned CHANNELS   = DEF_CHANNELS,
    parameter int unsigned WIN_BITS   = DEF_WIN_BITS,
    parameter int unsigned ZERO_LIMIT = DEF_ZERO_LIMIT,
    parameter int unsigned WORD_W     = DEF_WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CHANNELS-1:0] bit_en,
    input  logic [CHANNELS-1:0] bit_in,
    output logic [WORD_W-1:0]   status_word
);

    localparam int unsigned PAD_W = WORD_W - CHANNELS;

    win_grade_t          grades [CHANNELS];
    logic [CHANNELS-1:0] flags;

    // One independent detector slice per channel.
    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        ds2_ais_window #(
            .WIN_BITS   (WIN_BITS),
            .ZERO_LIMIT (ZERO_LIMIT)
        ) u_window (
            .clk    (clk),
            .rst_n  (rst_n),
            .bit_en (bit_en[ch]),
            .bit_in (bit_in[ch]),
            .grade  (grades[ch])
        );

        ds2_ais_hyst u_hyst (
            .clk      (clk),
            .rst_n    (rst_n),
            .grade    (grades[ch]),
            .ais_flag (flags[ch])
        );
    end

    // Register word: flags in the low bits, reserved bits tied to zero.
    if (PAD_W > 0) begin : g_pad
        assign status_word = {{PAD_W{1'b0}}, flags};
    end else begin : g_nopad
        assign status_word = flags;
    end

    // R8: one cycle after a reset edge, every flag reads zero.
    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (flags == '0))
        else $error("flags not cleared by reset");

endmodule

// File: tb/tb_ds2_ais_monitor.sv
`timescale 1ns/1ps
// Bench: sweeps per-window zero counts from 0 to 7 on all channels, at three
// strobe rates, with zeros at the head or the tail of a window. A behavioural
// per-channel model predicts the status word each cycle.
module tb_ds2_ais_monitor;

    localparam int NCH  = 7;
    localparam int WIN  = 840;
    localparam int ZLIM = 5;
    localparam int REGW = 16;
    localparam int RUN_CYCLES   = 45000;
    localparam int RESET_AT     = 20000;
    localparam int WATCHDOG_CYC = 200000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  en = '0;
    logic [NCH-1:0]  din = '0;
    logic [REGW-1:0] status;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int mcnt [NCH];
    int mz   [NCH];
    int mwin [NCH];
    bit mprev[NCH];
    bit mstat[NCH];

    ds2_ais_monitor dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (en),
        .bit_in      (din),
        .status_word (status)
    );

    always #4 clk = ~clk;

    function automatic int zeros_in(int ch, int w);
        return ((w / 2) * 5 + ch + (w % 2) * (ch % 3 + 1)) % 8;
    endfunction

    // Odd windows put their zeros at the tail, so the last bit can be a zero.
    function automatic logic bit_at(int ch, int w, int p);
        int nz = zeros_in(ch, w);
        if (w % 2) return (p >= WIN - nz) ? 1'b0 : 1'b1;
        return (p < nz) ? 1'b0 : 1'b1;
    endfunction

    function automatic logic [REGW-1:0] expected_word();
        logic [REGW-1:0] w = '0;
        for (int ch = 0; ch < NCH; ch++) w[ch] = mstat[ch];
        return w;
    endfunction

    task automatic model_reset();
        for (int ch = 0; ch < NCH; ch++) begin
            mcnt[ch] = 0; mz[ch] = 0; mwin[ch] = 0;
            mprev[ch] = 0; mstat[ch] = 0;
        end
    endtask

    // Consume the bits that the last rising edge took.
    task automatic model_step();
        for (int ch = 0; ch < NCH; ch++) begin
            if (en[ch]) begin
                if (!din[ch]) mz[ch]++;
                mcnt[ch]++;
                if (mcnt[ch] == WIN) begin
                    bit like = (mz[ch] < ZLIM);
                    if (like == mprev[ch]) mstat[ch] = like;
                    mprev[ch] = like;
                    mcnt[ch] = 0;
                    mz[ch] = 0;
                    mwin[ch]++;
                end
            end
        end
    endtask

    // Strobe rates 1, 1/2, 1/3; data forced to 0 while the strobe is low.
    task automatic drive(int cyc);
        for (int ch = 0; ch < NCH; ch++) begin
            en[ch]  = ((cyc % (ch % 3 + 1)) == 0);
            din[ch] = en[ch] ? bit_at(ch, mwin[ch], mcnt[ch]) : 1'b0;
        end
    endtask

    task automatic check(bit ok, string tag, logic [REGW-1:0] act, logic [REGW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(status == '0, "R8 reset state", status, '0);
        rst_n = 1'b1;
        drive(0);
        for (int cyc = 1; cyc <= RUN_CYCLES; cyc++) begin
            @(negedge clk);
            model_step();
            check(status == expected_word(), "R1/R2/R3/R4/R5/R6 status", status, expected_word());
            if (cyc % 4096 == 0)
                check(status[REGW-1:NCH] == '0, "R7 reserved bits", status, expected_word());
            if (cyc == RESET_AT) begin
                rst_n = 1'b0;
                en = '0;
                din = '0;
                @(negedge clk);
                model_reset();
                check(status == '0, "R8 mid-run reset", status, '0);
                @(negedge clk);
                rst_n = 1'b1;
            end
            drive(cyc);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule